// File: doc/BRIEF.md
# GPIO Interrupt Port

An eight-pin general-purpose I/O port that is reached over a simple register bus. Each pin is an input or an output according to its direction bit. Data accesses use the address lines as a per-bit mask, so software can change or sample any subset of pins in a single access, with no read-modify-write. Every pin has its own interrupt detector. The detector can be set to edge or level sensing. In edge mode it responds to a rising edge, a falling edge or both edges. In level mode it responds to a high level or a low level.

Pin inputs pass through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier. Raw status is reported per pin, and masked status is the raw status ANDed with an enable mask. A single interrupt line is raised while any masked status bit is set. A separate one-cycle pulse output tells an external converter to start a sample sequence when a new unmasked event occurs on a pin whose trigger-enable bit is set.

Bus map: bits [11:10] of the address select the region (00 for data, 01 for control). In the data region, bits [9:2] are the pin mask. In the control region, bits [5:2] select the register by index: 0 direction, 1 sense select (1 = level), 2 both-edge select, 3 polarity (1 = rising or high), 4 interrupt mask, 5 raw status (read only), 6 masked status (read only), 7 status clear (write only, reads 0), 8 trigger enable. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high. Reads are combinational from `bus_addr`. Unused indices and unused regions read 0.

Top module: `gpio_irq_port`

## Requirements
- R1: A write to the data region changes only those output-latch bits whose address mask bit (address [9:2]) is 1. The other output bits keep their values.
- R2: A read of the data region returns 0 for bits whose mask bit is 0. For a selected bit it returns the output latch if the pin's direction bit is 1, and the synchronized input if the direction bit is 0.
- R3: `pin_oe` equals the direction register (index 0), bit for bit. `pin_out` equals the output latch.
- R4: A change on `pin_in` that is set up before clock edge k shows in a data read after edge k+1, and not before.
- R5: A pin in edge mode (sense bit 0) sets its raw status bit (index 5) after edge k+2 for an input change set up before edge k. The qualifying change is a rising edge when the both bit is 0 and polarity is 1, a falling edge when both is 0 and polarity is 0, and either edge when both is 1.
- R6: An edge-mode raw status bit stays set until a 1 is written to that bit of the clear register (index 7). Writing 0 bits to the clear register leaves the other status bits unchanged.
- R7: A pin in level mode (sense bit 1) has a raw status that follows the synchronized level condition: high when polarity is 1, low when polarity is 0. The bit is registered one cycle after the synchronized value, and a write to the clear register has no effect on it.
- R8: Masked status (index 6) equals raw status AND the mask register (index 4). `irq_out` is high exactly when masked status is nonzero.
- R9: `trig_out` is high for one cycle, aligned with the raw status update, for each new event on a pin whose mask bit and trigger-enable bit (index 8) are both 1. A new event is a qualifying edge, or the onset of a level condition.
- R10: After reset, every register, the synchronizer and all status bits are 0. `pin_oe`, `pin_out`, `irq_out` and `trig_out` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, to be released synchronously to clk |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 12 | Byte address; region, register index and data mask |
| bus_wdata | input | 32 | Write data; bits above the pin count are ignored |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Output latch driven to the pads |
| pin_oe | output | 8 | Per-pin output enable |
| irq_out | output | 1 | Combined masked interrupt |
| trig_out | output | 1 | One-cycle converter start pulse |

## Verification
Properties are checked on every clock edge. Data writes must never disturb bits outside the address mask. A set edge-mode status bit must persist unless it is cleared. An edge-mode status bit may only rise after a real transition at the synchronizer output. A level-mode status bit must equal the level condition of the previous cycle. A trigger pulse needs both a mask bit and a trigger-enable bit. The interrupt output must stay low while the mask is empty. Some behaviour only the bench's scenarios can show: the exact two-cycle synchronizer latency, the choice among rising, falling and both-edge detection, the fact that clears do not affect level-mode bits, and that a held level produces exactly one trigger pulse. The bench shows these by driving pin patterns and comparing every output and the read data against a behavioural model on each cycle.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  // Register index within the control region (address bits [5:2])
  typedef enum logic [3:0] {
    RIX_DIR    = 4'd0,
    RIX_SENSE  = 4'd1,
    RIX_BOTH   = 4'd2,
    RIX_POL    = 4'd3,
    RIX_MASK   = 4'd4,
    RIX_RAW    = 4'd5,
    RIX_MSTAT  = 4'd6,
    RIX_CLEAR  = 4'd7,
    RIX_TRIGEN = 4'd8
  } gpio_reg_e;

  // Region select (top two address bits)
  localparam logic [1:0] SPACE_DATA = 2'b00;
  localparam logic [1:0] SPACE_CTRL = 2'b01;

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] ten_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mstat_o,
  output logic         trig_o
);

  logic [W-1:0] lvl_hit, edge_hit, new_ev, raw_d, raw_q;
  logic         trig_d, trig_q;

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign lvl_hit[g]  = pol_i[g] ? sync_i[g] : ~sync_i[g];
    assign edge_hit[g] = both_i[g] ? (sync_i[g] ^ prev_i[g])
                       : (pol_i[g] ? (sync_i[g] & ~prev_i[g])
                                   : (~sync_i[g] & prev_i[g]));
    assign new_ev[g]   = sense_i[g] ? (lvl_hit[g] & ~raw_q[g]) : edge_hit[g];
    assign raw_d[g]    = sense_i[g] ? lvl_hit[g]
                                    : (edge_hit[g] | (raw_q[g] & ~clr_i[g]));
  end

  assign trig_d = |(new_ev & mask_i & ten_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      trig_q <= trig_d;
    end
  end

  assign raw_o   = raw_q;
  assign mstat_o = raw_q & mask_i;
  assign trig_o  = trig_q;

  // R6: a set edge-mode bit that was not cleared is still set next cycle
  a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(raw_q & ~clr_i & ~sense_i) & ~sense_i & ~raw_q) == '0));

  // R5: an edge-mode bit may only rise after a synchronized transition
  a_r5_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~$past(raw_q) & $past(~sense_i) & ~$past(sync_i ^ prev_i)) == '0));

  // R7: a level-mode bit equals last cycle's level condition
  a_r7_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (((raw_q ^ $past(lvl_hit)) & $past(sense_i)) == '0));

  // R9: a trigger pulse needs a pin both masked-in and trigger-enabled
  a_r9_trig_gated: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> ($past(mask_i & ten_i) != '0));

endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [W-1:0]  sync_i,
  input  logic [W-1:0]  raw_i,
  input  logic [W-1:0]  mstat_i,
  output logic [W-1:0]  dir_o,
  output logic [W-1:0]  out_o,
  output logic [W-1:0]  sense_o,
  output logic [W-1:0]  both_o,
  output logic [W-1:0]  pol_o,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  ten_o,
  output logic [W-1:0]  clr_o
);

  localparam int MLO = 2;
  localparam int MHI = W + 1;

  logic [1:0]   space;
  gpio_reg_e    idx;
  logic [W-1:0] amask, wval, rd_w;
  logic         wr_data, wr_ctrl;

  logic [W-1:0] dir_q, out_q, sense_q, both_q, pol_q, mask_q, ten_q;
  logic [W-1:0] dir_d, out_d, sense_d, both_d, pol_d, mask_d, ten_d;

  logic unused_bus;
  assign unused_bus = ^{bus_addr, bus_wdata};

  assign space   = bus_addr[AW-1:AW-2];
  assign idx     = gpio_reg_e'(bus_addr[5:2]);
  assign amask   = bus_addr[MHI:MLO];
  assign wval    = bus_wdata[W-1:0];
  assign wr_data = bus_sel && bus_wr && (space == SPACE_DATA);
  assign wr_ctrl = bus_sel && bus_wr && (space == SPACE_CTRL);

  // next-state
  always_comb begin
    dir_d   = dir_q;
    out_d   = out_q;
    sense_d = sense_q;
    both_d  = both_q;
    pol_d   = pol_q;
    mask_d  = mask_q;
    ten_d   = ten_q;
    clr_o   = '0;
    if (wr_data) begin
      out_d = (out_q & ~amask) | (wval & amask);
    end
    if (wr_ctrl) begin
      case (idx)
        RIX_DIR:    dir_d   = wval;
        RIX_SENSE:  sense_d = wval;
        RIX_BOTH:   both_d  = wval;
        RIX_POL:    pol_d   = wval;
        RIX_MASK:   mask_d  = wval;
        RIX_TRIGEN: ten_d   = wval;
        RIX_CLEAR:  clr_o   = wval;
        default:    ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
      ten_q   <= '0;
    end else begin
      dir_q   <= dir_d;
      out_q   <= out_d;
      sense_q <= sense_d;
      both_q  <= both_d;
      pol_q   <= pol_d;
      mask_q  <= mask_d;
      ten_q   <= ten_d;
    end
  end

  // read mux
  always_comb begin
    rd_w = '0;
    if (space == SPACE_DATA) begin
      rd_w = ((dir_q & out_q) | (~dir_q & sync_i)) & amask;
    end else if (space == SPACE_CTRL) begin
      case (idx)
        RIX_DIR:    rd_w = dir_q;
        RIX_SENSE:  rd_w = sense_q;
        RIX_BOTH:   rd_w = both_q;
        RIX_POL:    rd_w = pol_q;
        RIX_MASK:   rd_w = mask_q;
        RIX_RAW:    rd_w = raw_i;
        RIX_MSTAT:  rd_w = mstat_i;
        RIX_TRIGEN: rd_w = ten_q;
        default:    rd_w = '0;
      endcase
    end
  end

  assign bus_rdata = {{(DW-W){1'b0}}, rd_w};

  assign dir_o   = dir_q;
  assign out_o   = out_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;
  assign mask_o  = mask_q;
  assign ten_o   = ten_q;

  // R1: bits outside the write mask never move
  a_r1_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (((out_q ^ $past(out_q)) & ~$past(wr_data ? amask : '0)) == '0));

endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port #(
  parameter int NPINS = 8,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_out,
  output logic             trig_out
);

  logic [NPINS-1:0] sync_v, prev_v, raw_v, mstat_v;
  logic [NPINS-1:0] dir_v, out_v, sense_v, both_v, pol_v, mask_v, ten_v, clr_v;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_in),
    .sync_o (sync_v),
    .prev_o (prev_v)
  );

  gpio_regs #(.W(NPINS), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sync_i    (sync_v),
    .raw_i     (raw_v),
    .mstat_i   (mstat_v),
    .dir_o     (dir_v),
    .out_o     (out_v),
    .sense_o   (sense_v),
    .both_o    (both_v),
    .pol_o     (pol_v),
    .mask_o    (mask_v),
    .ten_o     (ten_v),
    .clr_o     (clr_v)
  );

  gpio_irq_detect #(.W(NPINS)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_v),
    .prev_i  (prev_v),
    .sense_i (sense_v),
    .both_i  (both_v),
    .pol_i   (pol_v),
    .mask_i  (mask_v),
    .ten_i   (ten_v),
    .clr_i   (clr_v),
    .raw_o   (raw_v),
    .mstat_o (mstat_v),
    .trig_o  (trig_out)
  );

  assign pin_out = out_v;
  assign pin_oe  = dir_v;
  assign irq_out = |mstat_v;

  // R8: an empty mask keeps the interrupt line low
  a_r8_no_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_v == '0) |-> !irq_out);

endmodule

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;

  localparam logic [11:0] C_DIR   = 12'h400;
  localparam logic [11:0] C_SENSE = 12'h404;
  localparam logic [11:0] C_BOTH  = 12'h408;
  localparam logic [11:0] C_POL   = 12'h40C;
  localparam logic [11:0] C_MASK  = 12'h410;
  localparam logic [11:0] C_RAW   = 12'h414;
  localparam logic [11:0] C_MSTAT = 12'h418;
  localparam logic [11:0] C_CLEAR = 12'h41C;
  localparam logic [11:0] C_TEN   = 12'h420;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = 12'h000;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = 8'h00;
  logic [7:0]  pin_out, pin_oe;
  logic        irq_out, trig_out;

  int tests = 0;
  int fails = 0;
  int trig_cnt = 0;

  always #2 clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_out(irq_out), .trig_out(trig_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_s1, m_s2, m_prev, m_raw, m_dir, m_out, m_sense, m_both, m_pol, m_mask, m_ten;
  logic [7:0] ev, nraw, clrv, wm;
  logic       m_trig;
  bit         s, p, lv, ed;

  function automatic logic [31:0] mread(input logic [11:0] a);
    logic [7:0] mk;
    mk = a[9:2];
    if (a[11:10] == 2'b00) return {24'h0, ((m_dir & m_out) | (~m_dir & m_s2)) & mk};
    if (a[11:10] != 2'b01) return 32'h0;
    case (a[5:2])
      4'd0: return {24'h0, m_dir};
      4'd1: return {24'h0, m_sense};
      4'd2: return {24'h0, m_both};
      4'd3: return {24'h0, m_pol};
      4'd4: return {24'h0, m_mask};
      4'd5: return {24'h0, m_raw};
      4'd6: return {24'h0, m_raw & m_mask};
      4'd8: return {24'h0, m_ten};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_raw = 0; m_dir = 0; m_out = 0;
      m_sense = 0; m_both = 0; m_pol = 0; m_mask = 0; m_ten = 0; m_trig = 0;
    end else begin
      clrv = (bus_sel && bus_wr && bus_addr[11:10] == 2'b01 && bus_addr[5:2] == 4'd7)
             ? bus_wdata[7:0] : 8'h00;
      for (int i = 0; i < 8; i++) begin
        s  = m_s2[i];
        p  = m_prev[i];
        lv = m_pol[i] ? s : !s;
        ed = m_both[i] ? (s != p) : (m_pol[i] ? (s && !p) : (!s && p));
        ev[i]   = m_sense[i] ? (lv && !m_raw[i]) : ed;
        nraw[i] = m_sense[i] ? lv : (ed || (m_raw[i] && !clrv[i]));
      end
      m_trig = |(ev & m_mask & m_ten);
      m_raw  = nraw;
      if (bus_sel && bus_wr) begin
        if (bus_addr[11:10] == 2'b00) begin
          wm    = bus_addr[9:2];
          m_out = (m_out & ~wm) | (bus_wdata[7:0] & wm);
        end else if (bus_addr[11:10] == 2'b01) begin
          case (bus_addr[5:2])
            4'd0: m_dir   = bus_wdata[7:0];
            4'd1: m_sense = bus_wdata[7:0];
            4'd2: m_both  = bus_wdata[7:0];
            4'd3: m_pol   = bus_wdata[7:0];
            4'd4: m_mask  = bus_wdata[7:0];
            4'd8: m_ten   = bus_wdata[7:0];
            default: ;
          endcase
        end
      end
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin_in;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1/R3 pin_out", {24'h0, pin_out}, {24'h0, m_out});
      chk("R3 pin_oe", {24'h0, pin_oe}, {24'h0, m_dir});
      chk("R8 irq_out", {31'h0, irq_out}, {31'h0, |(m_raw & m_mask)});
      chk("R9 trig_out", {31'h0, trig_out}, {31'h0, m_trig});
      chk("R2 bus_rdata", bus_rdata, mread(bus_addr));
      if (trig_out) trig_cnt++;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #0.2;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #0.2;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); #0.2;
    bus_addr = a;
    #0.2 v = bus_rdata;
  endtask

  task automatic setpins(input logic [7:0] v);
    @(negedge clk); #0.2;
    pin_in = v;
  endtask

  logic [31:0] v;
  int t0;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R10 reset state
    bus_addr = C_DIR;
    #0.4;
    chk("R10 pin_oe", {24'h0, pin_oe}, 32'h0);
    chk("R10 pin_out", {24'h0, pin_out}, 32'h0);
    chk("R10 irq_out", {31'h0, irq_out}, 32'h0);
    chk("R10 trig_out", {31'h0, trig_out}, 32'h0);
    chk("R10 dir read", bus_rdata, 32'h0);
    @(negedge clk); #0.2 rst_n = 1'b1;

    // R1, R3: masked writes
    wr(C_DIR, 32'hFF);
    chk("R3 oe all out", {24'h0, pin_oe}, 32'hFF);
    wr(12'h0F << 2, 32'hAA);
    chk("R1 low nibble", {24'h0, pin_out}, 32'h0A);
    wr(12'hF0 << 2, 32'h55);
    chk("R1 high nibble", {24'h0, pin_out}, 32'h5A);
    // R2: masked read
    rd(12'h3C << 2, v);
    chk("R2 masked read", v, 32'h18);

    // R4: synchronizer latency with lower nibble output, upper input
    wr(C_DIR, 32'h0F);
    rd(12'hFF << 2, v);
    chk("R2 mixed read", v, 32'h0A);
    @(negedge clk); #0.2 pin_in = 8'h81;
    #0.2 chk("R4 before edge", bus_rdata, 32'h0A);
    @(negedge clk); #0.4 chk("R4 after one edge", bus_rdata, 32'h0A);
    @(negedge clk); #0.4 chk("R4 after two edges", bus_rdata, 32'h8A);
    wr(C_DIR, 32'h00);
    setpins(8'h00);
    repeat (4) @(negedge clk);
    wr(C_CLEAR, 32'hFF);

    // R5: rising on pin0, falling on pin1, both on pin2
    wr(C_POL, 32'h01);
    wr(C_BOTH, 32'h04);
    wr(C_CLEAR, 32'hFF);
    rd(C_RAW, v);
    chk("R6 cleared", v, 32'h00);
    setpins(8'h07);
    @(negedge clk); @(negedge clk);
    rd(C_RAW, v);
    chk("R5 rise pattern", v, 32'h05);
    chk("R8 irq masked off", {31'h0, irq_out}, 32'h0);
    wr(C_CLEAR, 32'h07);
    setpins(8'h00);
    repeat (3) @(negedge clk);
    rd(C_RAW, v);
    chk("R5 fall pattern", v, 32'h06);

    // R8: masked status
    wr(C_MASK, 32'h04);
    rd(C_MSTAT, v);
    chk("R8 masked status", v, 32'h04);
    chk("R8 irq high", {31'h0, irq_out}, 32'h1);
    wr(C_MASK, 32'h01);
    rd(C_MSTAT, v);
    chk("R8 masked status off", v, 32'h00);

    // R6: latching and selective clear
    repeat (5) @(negedge clk);
    rd(C_RAW, v);
    chk("R6 held", v, 32'h06);
    wr(C_CLEAR, 32'h02);
    rd(C_RAW, v);
    chk("R6 partial clear", v, 32'h04);
    wr(C_CLEAR, 32'h04);
    rd(C_RAW, v);
    chk("R6 full clear", v, 32'h00);

    // R7: level high on pin3
    wr(C_POL, 32'h09);
    wr(C_SENSE, 32'h08);
    setpins(8'h08);
    repeat (4) @(negedge clk);
    rd(C_RAW, v);
    chk("R7 level set", v, 32'h08);
    wr(C_CLEAR, 32'h08);
    rd(C_RAW, v);
    chk("R7 clear ignored", v, 32'h08);
    setpins(8'h00);
    repeat (4) @(negedge clk);
    rd(C_RAW, v);
    chk("R7 level gone", v, 32'h00);

    // R9: trigger pulse gated by enable
    wr(C_MASK, 32'h08);
    wr(C_TEN, 32'h08);
    t0 = trig_cnt;
    setpins(8'h08);
    repeat (8) @(negedge clk);
    chk("R9 one pulse per level onset", trig_cnt - t0, 1);
    setpins(8'h00);
    repeat (4) @(negedge clk);
    wr(C_TEN, 32'h00);
    t0 = trig_cnt;
    setpins(8'h08);
    repeat (8) @(negedge clk);
    chk("R9 no pulse when disabled", trig_cnt - t0, 0);
    chk("R8 irq on level", {31'h0, irq_out}, 32'h1);

    // R9: both-edge pin with trigger, two toggles give two pulses
    wr(C_SENSE, 32'h00);
    wr(C_MASK, 32'h04);
    wr(C_TEN, 32'h04);
    t0 = trig_cnt;
    setpins(8'h04);
    repeat (5) @(negedge clk);
    setpins(8'h00);
    repeat (5) @(negedge clk);
    chk("R9 two edge pulses", trig_cnt - t0, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule